// File: doc/BRIEF.md
# TLB Range Invalidation Command Decoder

This block sits behind a command queue reader and turns 128-bit address-invalidation commands into a single, fully decoded invalidation request. Two command opcodes are handled. The first invalidates by virtual address within one address-space identifier. The second invalidates by virtual address across every address-space identifier. For either opcode the block extracts the address, the identifier, the granule code, the scale, the count and the level hint. It computes how many pages the range covers, the log2 of the granule, and the byte mask of the whole range.

The decoded request is registered once. It is then presented at the same time to two consumers: the TLB and a downstream listener that is notified of unmappings. Each consumer has its own valid/ready pair. A new command is taken only after both consumers have acknowledged the current one. Any other opcode is accepted at once and reported on a one-cycle unhandled strobe, so that another unit can deal with it. The block also drives a constant capability word that advertises range invalidation and hierarchical-disable support.

Top module: `rinv_decoder`

## Requirements
- R1: `cmd_ready` is high exactly when neither `tlb_valid` nor `ntf_valid` is high. A handled command accepted on a rising edge (`cmd_valid && cmd_ready`) raises both `tlb_valid` and `ntf_valid` after that same edge.
- R2: Command word n is `cmd_data[32n+31:32n]`. The fields are: opcode = word0[7:0], count = word0[16:12], scale = word0[24:20], level hint = word2[9:8], granule code = word2[11:10], identifier = word1[31:16], and address = {word3, word2[31:12], 12'h000}. The address appears on `req_addr` and the granule code on `req_tg`.
- R3: With a nonzero granule code, `req_pages` = (count + 1) << scale. The largest value is 2^36.
- R4: With a zero granule code, the scale, count and level hint are ignored. `req_pages` is 1, `req_gran` is 12 and `req_ttl` is 0.
- R5: With a nonzero granule code g, `req_gran` = 2·g + 10. So g=1 gives 12, g=2 gives 14 and g=3 gives 16.
- R6: `req_mask` = (`req_pages` << `req_gran`) − 1.
- R7: Opcode 8'h12 issues with the command's identifier and `req_any_asid` = 0. Opcode 8'h13 issues with `req_any_asid` = 1 and `req_asid` = 0.
- R8: `req_exact` is 1 when the level hint forwarded on `req_ttl` is nonzero and `req_pages` is 1. Otherwise it is 0.
- R9: Each of `tlb_valid` and `ntf_valid` stays high until its own ready is seen high on a rising edge, independently of the other. All `req_*` outputs hold steady while either valid is high. A command offered while busy is not taken.
- R10: Any other opcode is accepted whenever `cmd_ready` is high. After the accepting edge, `unh_valid` is high for one cycle with `unh_type` equal to the opcode, and no request is raised.
- R11: `cap_word` is 32'h0000_0404. Bit 10 flags range invalidation and bit 2 flags hierarchical-disable support.
- R12: During and after reset, `tlb_valid`, `ntf_valid` and `unh_valid` are 0 and `cmd_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Decoder can take a command |
| cmd_data | input | 128 | Four 32-bit command words |
| tlb_valid | output | 1 | Request pending toward the TLB |
| tlb_ready | input | 1 | TLB takes the request |
| ntf_valid | output | 1 | Request pending toward the notification listener |
| ntf_ready | input | 1 | Listener takes the request |
| req_asid | output | 16 | Identifier to match (0 when any) |
| req_any_asid | output | 1 | Match every identifier |
| req_addr | output | 64 | Base address of the range |
| req_mask | output | 64 | Byte mask of the whole range |
| req_pages | output | 37 | Number of granule-sized pages |
| req_gran | output | 5 | log2 of the range granule |
| req_tg | output | 2 | Granule code from the command |
| req_ttl | output | 2 | Level hint (0 when the code is zero) |
| req_exact | output | 1 | Single entry at a known level |
| unh_valid | output | 1 | Unhandled opcode strobe |
| unh_type | output | 8 | Opcode of the unhandled command |
| cap_word | output | 32 | Constant capability flags |

## Verification
The decode path is tried with a table of commands that covers every granule code. It includes a zero code carrying nonzero scale, count and hint, which shows that ignored fields really are dropped. It includes single-page commands with and without a level hint, which separate the exact flag from range handling. It also includes the largest count and scale together, which exposes any truncation in the page count or the mask. Both handled opcodes appear with a nonzero identifier, so identifier forwarding can be told apart from the any-identifier case. Directed sequences then acknowledge the two consumers at different times, offer a command while the block is busy, and send an unknown opcode.

// File: rtl/rinv_pkg.sv
package rinv_pkg;
    localparam int CMD_W    = 128;
    localparam int WORD_W   = 32;
    localparam int OPC_W    = 8;
    localparam int NUM_W    = 5;
    localparam int SCALE_W  = 5;
    localparam int HINT_W   = 2;
    localparam int TG_W     = 2;
    localparam int GRAN_W   = 5;
    localparam int PAGE_W   = NUM_W + 1 + (2 ** SCALE_W) - 1;

    localparam int OPC_LSB   = 0;
    localparam int NUM_LSB   = 12;
    localparam int SCALE_LSB = 20;
    localparam int HINT_LSB  = 8;
    localparam int TG_LSB    = 10;
    localparam int ID_LSB    = 16;
    localparam int ADDR_LSB  = 12;

    localparam logic [31:0] CAP_FLAGS = (32'h1 << 10) | (32'h1 << 2);

    typedef struct packed {
        logic [OPC_W-1:0]   opc;
        logic [NUM_W-1:0]   num;
        logic [SCALE_W-1:0] scale;
        logic [HINT_W-1:0]  hint;
        logic [TG_W-1:0]    tg;
    } ctl_fields_t;
endpackage

// File: rtl/rinv_fields.sv
module rinv_fields
    import rinv_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int ASID_W = 16
) (
    input  logic [CMD_W-1:0]  cmd,
    output ctl_fields_t       ctl,
    output logic [ASID_W-1:0] asid,
    output logic [ADDR_W-1:0] addr
);
    localparam int NWORDS = CMD_W / WORD_W;

    logic [WORD_W-1:0] w [NWORDS];
    logic [63:0]       full_addr;
    logic              unused_bits;

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        assign w[i] = cmd[i*WORD_W +: WORD_W];
    end

    always_comb begin
        ctl.opc   = w[0][OPC_LSB   +: OPC_W];
        ctl.num   = w[0][NUM_LSB   +: NUM_W];
        ctl.scale = w[0][SCALE_LSB +: SCALE_W];
        ctl.hint  = w[2][HINT_LSB  +: HINT_W];
        ctl.tg    = w[2][TG_LSB    +: TG_W];
        full_addr = {w[3], w[2][WORD_W-1:ADDR_LSB], {ADDR_LSB{1'b0}}};
        addr      = full_addr[ADDR_W-1:0];
        asid      = w[1][ID_LSB +: ASID_W];
    end

    assign unused_bits = ^cmd;
endmodule

// File: rtl/rinv_range.sv
module rinv_range
    import rinv_pkg::*;
#(
    parameter int ADDR_W   = 64,
    parameter int DEF_GRAN = 12
) (
    input  logic [TG_W-1:0]    tg,
    input  logic [HINT_W-1:0]  hint,
    input  logic [NUM_W-1:0]   num,
    input  logic [SCALE_W-1:0] scale,
    output logic [PAGE_W-1:0]  pages,
    output logic [GRAN_W-1:0]  gran,
    output logic [HINT_W-1:0]  hint_eff,
    output logic [ADDR_W-1:0]  mask,
    output logic               exact
);
    logic [PAGE_W-1:0] base_cnt;
    logic [ADDR_W-1:0] span;

    always_comb begin
        if (tg != '0) begin
            base_cnt = PAGE_W'(num) + PAGE_W'(1);
            pages    = base_cnt << scale;
            gran     = GRAN_W'({tg, 1'b0}) + GRAN_W'(10);
            hint_eff = hint;
        end else begin
            base_cnt = PAGE_W'(1);
            pages    = PAGE_W'(1);
            gran     = GRAN_W'(DEF_GRAN);
            hint_eff = '0;
        end
        span  = ADDR_W'(pages) << gran;
        mask  = span - ADDR_W'(1);
        exact = (hint_eff != '0) && (pages == PAGE_W'(1));
    end
endmodule

// File: rtl/rinv_port.sv
module rinv_port (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic ready,
    output logic valid
);
    typedef struct packed {
        logic pend;
    } port_st_t;

    port_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.pend = 1'b1;
        end else if (st_q.pend && ready) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.pend;

    AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> valid); // R9
endmodule

// File: rtl/rinv_decoder.sv
module rinv_decoder
    import rinv_pkg::*;
#(
    parameter int          ADDR_W   = 64,
    parameter int          ASID_W   = 16,
    parameter int          DEF_GRAN = 12,
    parameter logic [7:0]  OPC_VA   = 8'h12,
    parameter logic [7:0]  OPC_VAA  = 8'h13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [127:0]      cmd_data,
    output logic              tlb_valid,
    input  logic              tlb_ready,
    output logic              ntf_valid,
    input  logic              ntf_ready,
    output logic [15:0]       req_asid,
    output logic              req_any_asid,
    output logic [63:0]       req_addr,
    output logic [63:0]       req_mask,
    output logic [36:0]       req_pages,
    output logic [4:0]        req_gran,
    output logic [1:0]        req_tg,
    output logic [1:0]        req_ttl,
    output logic              req_exact,
    output logic              unh_valid,
    output logic [7:0]        unh_type,
    output logic [31:0]       cap_word
);
    localparam int NCH = 2;

    typedef struct packed {
        logic [ASID_W-1:0] asid;
        logic              any;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mask;
        logic [PAGE_W-1:0] pages;
        logic [GRAN_W-1:0] gran;
        logic [TG_W-1:0]   tg;
        logic [HINT_W-1:0] hint;
        logic              exact;
    } req_t;

    typedef struct packed {
        req_t             req;
        logic             unh;
        logic [OPC_W-1:0] unh_opc;
    } dec_st_t;

    dec_st_t st_d, st_q;

    ctl_fields_t       ctl;
    logic [ASID_W-1:0] f_asid;
    logic [ADDR_W-1:0] f_addr;
    logic [PAGE_W-1:0] r_pages;
    logic [GRAN_W-1:0] r_gran;
    logic [HINT_W-1:0] r_hint;
    logic [ADDR_W-1:0] r_mask;
    logic              r_exact;
    logic              accept;
    logic              handled;
    logic              is_all;
    logic [NCH-1:0]    ch_ready;
    logic [NCH-1:0]    ch_valid;

    rinv_fields #(.ADDR_W(ADDR_W), .ASID_W(ASID_W)) u_fields (
        .cmd  (cmd_data),
        .ctl  (ctl),
        .asid (f_asid),
        .addr (f_addr)
    );

    rinv_range #(.ADDR_W(ADDR_W), .DEF_GRAN(DEF_GRAN)) u_range (
        .tg       (ctl.tg),
        .hint     (ctl.hint),
        .num      (ctl.num),
        .scale    (ctl.scale),
        .pages    (r_pages),
        .gran     (r_gran),
        .hint_eff (r_hint),
        .mask     (r_mask),
        .exact    (r_exact)
    );

    assign ch_ready  = {ntf_ready, tlb_ready};
    assign cmd_ready = ~(|ch_valid);
    assign accept    = cmd_valid && cmd_ready;
    assign is_all    = (ctl.opc == OPC_VAA);
    assign handled   = (ctl.opc == OPC_VA) || is_all;

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        rinv_port u_port (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (accept && handled),
            .ready (ch_ready[c]),
            .valid (ch_valid[c])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.unh = 1'b0;
        if (accept) begin
            if (handled) begin
                st_d.req.asid  = is_all ? '0 : f_asid;
                st_d.req.any   = is_all;
                st_d.req.addr  = f_addr;
                st_d.req.mask  = r_mask;
                st_d.req.pages = r_pages;
                st_d.req.gran  = r_gran;
                st_d.req.tg    = ctl.tg;
                st_d.req.hint  = r_hint;
                st_d.req.exact = r_exact;
            end else begin
                st_d.unh     = 1'b1;
                st_d.unh_opc = ctl.opc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tlb_valid    = ch_valid[0];
    assign ntf_valid    = ch_valid[1];
    assign req_asid     = 16'(st_q.req.asid);
    assign req_any_asid = st_q.req.any;
    assign req_addr     = 64'(st_q.req.addr);
    assign req_mask     = 64'(st_q.req.mask);
    assign req_pages    = st_q.req.pages;
    assign req_gran     = st_q.req.gran;
    assign req_tg       = st_q.req.tg;
    assign req_ttl      = st_q.req.hint;
    assign req_exact    = st_q.req.exact;
    assign unh_valid    = st_q.unh;
    assign unh_type     = st_q.unh_opc;
    assign cap_word     = CAP_FLAGS;

    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_valid || ntf_valid) |-> !cmd_ready); // R1
    AST_PAYLOAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_valid || ntf_valid) |=> (!(tlb_valid || ntf_valid) || ($stable(req_addr) && $stable(req_mask)))); // R9
    AST_ZERO_CODE_ONE_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_valid && req_tg == 2'd0) |-> (req_pages == 37'd1 && req_ttl == 2'd0)); // R4
    AST_MASK_COVERS_GRAN: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_valid |-> ((req_mask & ((64'd1 << req_gran) - 64'd1)) == ((64'd1 << req_gran) - 64'd1))); // R6
    AST_ANY_ID_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_valid && req_any_asid) |-> (req_asid == 16'd0)); // R7
    AST_UNH_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tlb_valid) |-> !unh_valid); // R10
endmodule

// File: tb/sim_rinv_decoder.sv
module sim_rinv_decoder;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [127:0] cmd_data = '0;
    logic         tlb_valid, ntf_valid;
    logic         tlb_ready = 1'b0;
    logic         ntf_ready = 1'b0;
    logic [15:0]  req_asid;
    logic         req_any_asid;
    logic [63:0]  req_addr, req_mask;
    logic [36:0]  req_pages;
    logic [4:0]   req_gran;
    logic [1:0]   req_tg, req_ttl;
    logic         req_exact, unh_valid;
    logic [7:0]   unh_type;
    logic [31:0]  cap_word;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    rinv_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .tlb_valid(tlb_valid), .tlb_ready(tlb_ready),
        .ntf_valid(ntf_valid), .ntf_ready(ntf_ready), .req_asid(req_asid),
        .req_any_asid(req_any_asid), .req_addr(req_addr), .req_mask(req_mask),
        .req_pages(req_pages), .req_gran(req_gran), .req_tg(req_tg),
        .req_ttl(req_ttl), .req_exact(req_exact), .unh_valid(unh_valid),
        .unh_type(unh_type), .cap_word(cap_word)
    );

    typedef struct packed {
        logic [7:0]  opc;
        logic [15:0] asid;
        logic [63:0] addr;
        logic [1:0]  tg;
        logic [1:0]  ttl;
        logic [4:0]  num;
        logic [4:0]  scale;
        logic [36:0] e_pages;
        logic [4:0]  e_gran;
        logic [63:0] e_mask;
        logic        e_exact;
        logic        e_any;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VT [NV] = '{
        '{8'h12, 16'h1234, 64'h0000_0012_3456_7000, 2'd0, 2'd2, 5'd7,  5'd3,  37'd1,             5'd12, 64'h0000_0000_0000_0FFF, 1'b0, 1'b0},
        '{8'h12, 16'h0042, 64'h0000_0000_8000_0000, 2'd1, 2'd3, 5'd0,  5'd0,  37'd1,             5'd12, 64'h0000_0000_0000_0FFF, 1'b1, 1'b0},
        '{8'h13, 16'h7777, 64'h0000_0001_0000_0000, 2'd1, 2'd0, 5'd3,  5'd2,  37'd16,            5'd12, 64'h0000_0000_0000_FFFF, 1'b0, 1'b1},
        '{8'h12, 16'hABCD, 64'h0000_0000_0000_4000, 2'd2, 2'd1, 5'd1,  5'd0,  37'd2,             5'd14, 64'h0000_0000_0000_7FFF, 1'b0, 1'b0},
        '{8'h12, 16'h0001, 64'hFFFF_0000_0001_0000, 2'd3, 2'd2, 5'd0,  5'd0,  37'd1,             5'd16, 64'h0000_0000_0000_FFFF, 1'b1, 1'b0},
        '{8'h13, 16'h5555, 64'h0000_0000_0000_0000, 2'd3, 2'd1, 5'd31, 5'd31, 37'h10_0000_0000,  5'd16, 64'h000F_FFFF_FFFF_FFFF, 1'b0, 1'b1},
        '{8'h12, 16'hFFFF, 64'h0000_0000_0020_0000, 2'd2, 2'd0, 5'd31, 5'd0,  37'd32,            5'd14, 64'h0000_0000_0007_FFFF, 1'b0, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [127:0] build(input logic [7:0] opc, input logic [15:0] asid,
                                           input logic [63:0] addr, input logic [1:0] tg,
                                           input logic [1:0] ttl, input logic [4:0] num,
                                           input logic [4:0] scale);
        logic [31:0] w0, w1, w2, w3;
        w0 = {7'd0, scale, 3'd0, num, 4'd0, opc};
        w1 = {asid, 16'd0};
        w2 = {addr[31:12], tg, ttl, 8'd0};
        w3 = addr[63:32];
        return {w3, w2, w1, w0};
    endfunction

    task automatic offer(input logic [127:0] c);
        @(negedge clk);
        cmd_data  = c;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic ack_both();
        tlb_ready = 1'b1;
        ntf_ready = 1'b1;
        @(negedge clk);
        tlb_ready = 1'b0;
        ntf_ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 act=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R12 reset state
        repeat (2) @(negedge clk);
        chk("R12 cmd_ready in reset", 64'(cmd_ready), 64'd1);
        chk("R12 tlb_valid in reset", 64'(tlb_valid), 64'd0);
        chk("R12 ntf_valid in reset", 64'(ntf_valid), 64'd0);
        chk("R12 unh_valid in reset", 64'(unh_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 cmd_ready after reset", 64'(cmd_ready), 64'd1);
        chk("R11 capability word", 64'(cap_word), 64'h404);

        // vector table: R2 R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            offer(build(VT[i].opc, VT[i].asid, VT[i].addr, VT[i].tg, VT[i].ttl, VT[i].num, VT[i].scale));
            chk("R1 tlb_valid raised", 64'(tlb_valid), 64'd1);
            chk("R1 ntf_valid raised", 64'(ntf_valid), 64'd1);
            chk("R1 cmd_ready low when busy", 64'(cmd_ready), 64'd0);
            chk("R2 address", req_addr, VT[i].addr);
            chk("R2 granule code", 64'(req_tg), 64'(VT[i].tg));
            chk("R3 page count", 64'(req_pages), 64'(VT[i].e_pages));
            chk("R5 granule log2", 64'(req_gran), 64'(VT[i].e_gran));
            chk("R6 range mask", req_mask, VT[i].e_mask);
            chk("R8 exact flag", 64'(req_exact), 64'(VT[i].e_exact));
            chk("R7 any identifier", 64'(req_any_asid), 64'(VT[i].e_any));
            chk("R7 identifier", 64'(req_asid), VT[i].e_any ? 64'd0 : 64'(VT[i].asid));
            chk("R4 hint forwarded", 64'(req_ttl), (VT[i].tg == 2'd0) ? 64'd0 : 64'(VT[i].ttl));
            ack_both();
            chk("R9 both acked", 64'(tlb_valid | ntf_valid), 64'd0);
        end

        // R9 independent acknowledgements and busy refusal
        offer(build(8'h12, 16'h0101, 64'h0000_0000_AAAA_A000, 2'd1, 2'd1, 5'd0, 5'd0));
        @(negedge clk);
        cmd_data  = build(8'h12, 16'h0202, 64'h0000_0000_BBBB_B000, 2'd1, 2'd0, 5'd1, 5'd0);
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk("R9 busy command refused", req_addr, 64'h0000_0000_AAAA_A000);
        chk("R9 tlb still pending", 64'(tlb_valid), 64'd1);
        tlb_ready = 1'b1;
        @(negedge clk);
        tlb_ready = 1'b0;
        chk("R9 tlb dropped on ack", 64'(tlb_valid), 64'd0);
        chk("R9 ntf held without ack", 64'(ntf_valid), 64'd1);
        chk("R1 still blocked", 64'(cmd_ready), 64'd0);
        chk("R9 payload held", 64'(req_asid), 64'h0101);
        ntf_ready = 1'b1;
        @(negedge clk);
        ntf_ready = 1'b0;
        chk("R9 ntf dropped on ack", 64'(ntf_valid), 64'd0);
        chk("R1 ready again", 64'(cmd_ready), 64'd1);

        // R10 unhandled opcode
        offer(build(8'h20, 16'h0303, 64'h0000_0000_CCCC_C000, 2'd2, 2'd2, 5'd2, 5'd2));
        chk("R10 unhandled strobe", 64'(unh_valid), 64'd1);
        chk("R10 unhandled opcode", 64'(unh_type), 64'h20);
        chk("R10 no tlb request", 64'(tlb_valid), 64'd0);
        chk("R10 no listener request", 64'(ntf_valid), 64'd0);
        chk("R10 ready stays high", 64'(cmd_ready), 64'd1);
        @(negedge clk);
        chk("R10 strobe one cycle", 64'(unh_valid), 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule